// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Access

This block is a watchdog countdown timer reached through a small register port. Two 16-bit registers sit at neighbouring halfword offsets. The count register is loaded by a write, and a read returns the number of ticks that remain. The control register holds an enable bit. A prescaler divides the system clock into coarse ticks. The parameter gives the tick length in clock cycles, and each tick stands for 128 ms. While the timer is enabled, the count drops by one on each tick. When it reaches zero, the block gives a single-cycle expiry pulse.

Software starts the timer in two steps: it writes the count, then writes the start pattern 0x85 to the control register. It keeps the timer alive by writing the count value again. To stop it, software does a read-modify-write that clears bit 0.

A side port converts a timeout given in whole seconds into ticks and loads the count with the result. It rejects a value of zero or a value above the largest count that can be represented. A second output turns the live count back into whole seconds remaining.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the count reads 0, the control register reads 0, and the expiry pulse and the reject flag are both low.
- R2: A write to byte offset 0x70 loads the count with the 16-bit data. A read at 0x70 returns the live count. While bit 0 of the control register is 0, the count does not change.
- R3: A write to offset 0x72 stores data bits 7:0. A read there returns those 8 bits with bits 15:8 as zero. Bit 0 is the enable, and writing 0x85 starts the timer.
- R4: While enabled, the count falls by exactly one every TICK_CYC clock cycles. The first step comes TICK_CYC cycles after the edge that set the enable or loaded the count.
- R5: When a tick takes the count from 1 to 0 while enabled, the expiry output is high for exactly one cycle. The count then stays at 0 and gives no further pulse until it is written again.
- R6: Clearing bit 0 freezes the count at its current value and blocks the expiry pulse. Setting bit 0 again resumes counting from the frozen value.
- R7: A write to the count while enabled (keepalive) restarts both the countdown and the tick phase from the new value.
- R8: A seconds request S with 1 <= S <= 8388 loads the count with floor(S*1000/128), for example 1 gives 7 and 8388 gives 65531. A count write in the same cycle takes priority over the request.
- R9: A seconds request of 0 or above 8388 leaves the count unchanged and raises the reject flag for the one cycle after the request.
- R10: The seconds-left output always equals floor(count*128/1000).
- R11: Writes to any address other than 0x70 and 0x72 change nothing, and reads there return 0.
- R12: Loading a count of 0 while enabled produces no expiry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| sec_load | input | 1 | Request to load a timeout given in seconds |
| sec_val | input | 16 | Timeout in seconds |
| sec_rej | output | 1 | Previous seconds request was out of range |
| sec_left | output | 16 | Whole seconds remaining on the count |
| wdt_expired | output | 1 | One-cycle pulse when the count runs out |

## Verification
The checker watches the countdown on every cycle. Without a load, the count may only hold or drop by one. It must stay fixed while disabled. The expiry pulse must last one cycle, may appear only with the count at zero, and may never come from a zero count or while the timer is off. A reject must always follow a request. The exact tick spacing, the values produced by the seconds conversion, the masking of the upper bits in the control register, the effect of a keepalive on the tick phase, and the silence of unmapped addresses all depend on concrete numbers. Only the bench scenarios can show those, by sampling the count and the outputs at the cycles that the requirements predict.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      REG_NONE  = 2'd0,
      REG_COUNT = 2'd1,
      REG_CTRL  = 2'd2
   } wdt_reg_e;

   localparam int DEF_ADDR_W      = 8;
   localparam int DEF_CNT_W       = 16;
   localparam int DEF_CTL_W       = 8;
   localparam int DEF_MS_PER_TICK = 128;
   localparam int DEF_COUNT_OFS   = 'h70;
   localparam int DEF_CTRL_OFS    = 'h72;

endpackage

// File: rtl/wdt_regdec.sv
module wdt_regdec
   import wdt_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int COUNT_OFS = DEF_COUNT_OFS,
   parameter int CTRL_OFS  = DEF_CTRL_OFS
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output wdt_reg_e          reg_sel,
   output logic              count_wr,
   output logic              ctrl_wr
);

   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);

   always_comb begin
      if (bus_addr == A_COUNT)
         reg_sel = REG_COUNT;
      else if (bus_addr == A_CTRL)
         reg_sel = REG_CTRL;
      else
         reg_sel = REG_NONE;
   end

   assign count_wr = bus_wr && (reg_sel == REG_COUNT);
   assign ctrl_wr  = bus_wr && (reg_sel == REG_CTRL);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int TICK_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);

   generate
      if (TICK_CYC == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_divider
         localparam int PRE_W = $clog2(TICK_CYC);
         localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYC - 1);
         logic [PRE_W-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               phase_q <= '0;
            else if (!run || restart)
               phase_q <= '0;
            else if (phase_q == LAST)
               phase_q <= '0;
            else
               phase_q <= phase_q + PRE_W'(1);
         end

         assign tick = run && (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/wdt_sec2tick.sv
module wdt_sec2tick #(
   parameter int CNT_W       = 16,
   parameter int SEC_W       = 16,
   parameter int MS_PER_TICK = 128
) (
   input  logic [SEC_W-1:0] sec_in,
   output logic [CNT_W-1:0] ticks_out,
   output logic             sec_ok,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [SEC_W-1:0] secs_left
);

   localparam int              PW        = SEC_W + CNT_W + 12;
   localparam longint unsigned MS_PER_S  = 1000;
   localparam longint unsigned MAX_TICKS = (64'd1 << CNT_W) - 64'd1;
   localparam longint unsigned MAX_SEC   = (MAX_TICKS * MS_PER_TICK) / MS_PER_S;
   localparam int              SH        = $clog2(MS_PER_TICK);
   localparam bit              POW2      = ((1 << SH) == MS_PER_TICK);

   logic [PW-1:0] sec_w;
   logic [PW-1:0] ms_w;
   logic [PW-1:0] cnt_ms_w;

   assign sec_w    = PW'(sec_in);
   assign ms_w     = sec_w * PW'(MS_PER_S);
   assign cnt_ms_w = PW'(cnt_in) * PW'(MS_PER_TICK);
   assign sec_ok   = (sec_w != '0) && (sec_w <= PW'(MAX_SEC));

   generate
      if (POW2) begin : g_shift
         assign ticks_out = CNT_W'(ms_w >> SH);
      end else begin : g_divide
         assign ticks_out = CNT_W'(ms_w / PW'(MS_PER_TICK));
      end
   endgenerate

   assign secs_left = SEC_W'(cnt_ms_w / PW'(MS_PER_S));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (load) begin
            cnt <= load_val;
         end else if (tick && (cnt != '0)) begin
            cnt <= cnt - ONE;
            if (cnt == ONE)
               expire <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int ADDR_W      = DEF_ADDR_W,
   parameter int CNT_W       = DEF_CNT_W,
   parameter int CTL_W       = DEF_CTL_W,
   parameter int SEC_W       = 16,
   parameter int TICK_CYC    = 4,
   parameter int MS_PER_TICK = DEF_MS_PER_TICK,
   parameter int COUNT_OFS   = DEF_COUNT_OFS,
   parameter int CTRL_OFS    = DEF_CTRL_OFS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              sec_load,
   input  logic [SEC_W-1:0]  sec_val,
   output logic              sec_rej,
   output logic [SEC_W-1:0]  sec_left,
   output logic              wdt_expired
);

   localparam int EN_BIT = 0;

   initial begin : p_param_chk
      if (CTL_W > CNT_W || CTL_W < 1)
         $error("control width must be between 1 and the count width");
      if (TICK_CYC < 1)
         $error("tick length must be at least one cycle");
      if (MS_PER_TICK < 1)
         $error("tick duration must be positive");
   end

   wdt_reg_e         reg_sel;
   logic             count_wr;
   logic             ctrl_wr;
   logic [CTL_W-1:0] ctl_q;
   logic             run_en;
   logic             tick;
   logic             cnt_load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] conv_ticks;
   logic             conv_ok;
   logic             sec_take;

   wdt_regdec #(
      .ADDR_W    (ADDR_W),
      .COUNT_OFS (COUNT_OFS),
      .CTRL_OFS  (CTRL_OFS)
   ) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .reg_sel  (reg_sel),
      .count_wr (count_wr),
      .ctrl_wr  (ctrl_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         sec_rej <= 1'b0;
      end else begin
         if (ctrl_wr)
            ctl_q <= bus_wdata[CTL_W-1:0];
         sec_rej <= sec_load && !conv_ok;
      end
   end

   assign run_en = ctl_q[EN_BIT];

   wdt_sec2tick #(
      .CNT_W       (CNT_W),
      .SEC_W       (SEC_W),
      .MS_PER_TICK (MS_PER_TICK)
   ) u_conv (
      .sec_in    (sec_val),
      .ticks_out (conv_ticks),
      .sec_ok    (conv_ok),
      .cnt_in    (cnt_q),
      .secs_left (sec_left)
   );

   assign sec_take = sec_load && conv_ok && !count_wr;
   assign cnt_load = count_wr || sec_take;
   assign load_val = count_wr ? bus_wdata : conv_ticks;

   wdt_prescaler #(
      .TICK_CYC (TICK_CYC)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_en),
      .restart (cnt_load),
      .tick    (tick)
   );

   wdt_countdown #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (load_val),
      .tick     (tick),
      .cnt      (cnt_q),
      .expire   (wdt_expired)
   );

   always_comb begin
      case (reg_sel)
         REG_COUNT: bus_rdata = cnt_q;
         REG_CTRL:  bus_rdata = CNT_W'(ctl_q);
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic             load,
   input logic             timeout,
   input logic             sec_load,
   input logic             sec_rej
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   a_r4_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - STEP));

   a_r5_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (cnt == '0));

   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   a_r6_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(cnt));

   a_r6_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !timeout);

   a_r9_reject_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rej |-> $past(sec_load));

   a_r12_zero_stays_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> !timeout);

endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt_q),
   .en       (run_en),
   .load     (cnt_load),
   .timeout  (wdt_expired),
   .sec_load (sec_load),
   .sec_rej  (sec_rej)
);

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;

   localparam int TICK = 4;
   localparam int MAXS = 65535 * 128 / 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic        sec_load = 1'b0;
   logic [15:0] sec_val = 16'h0000;
   logic        sec_rej;
   logic [15:0] sec_left;
   logic        wdt_expired;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   wdt_timer #(.TICK_CYC(TICK)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .sec_load    (sec_load),
      .sec_val     (sec_val),
      .sec_rej     (sec_rej),
      .sec_left    (sec_left),
      .wdt_expired (wdt_expired)
   );

   always @(negedge clk) if (rst_n && wdt_expired) pulses++;

   function automatic int f_ticks(int s);
      return s * 1000 / 128;
   endfunction

   function automatic int f_left(int c);
      return c * 128 / 1000;
   endfunction

   function automatic bit f_ok(int s);
      return (s >= 1) && (s <= MAXS);
   endfunction

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [7:0] a, logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic sec_req(int s);
      sec_val  = 16'(s);
      sec_load = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sec_load = 1'b0;
      #1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired got=hang exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int v;
      int c0;
      int p0;
      int unsigned seed;
      seed = $urandom(32'd2718);

      repeat (3) @(negedge clk);
      bus_read(8'h70, v); chk("R1 count after reset", v, 0);
      bus_read(8'h72, v); chk("R1 control after reset", v, 0);
      chk("R1 expiry after reset", int'(wdt_expired), 0);
      chk("R1 reject after reset", int'(sec_rej), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: load while disabled, no counting
      bus_write(8'h70, 16'd1000);
      wait_cyc(5 * TICK);
      bus_read(8'h70, v); chk("R2 count held while disabled", v, 1000);
      chk("R10 seconds left for 1000", int'(sec_left), f_left(1000));

      // R3 and R4: start with upper garbage, then step timing
      bus_write(8'h72, 16'hFF85);
      bus_read(8'h72, v); chk("R3 control readback masked", v, 16'h0085);
      wait_cyc(3 * TICK - 1);
      bus_read(8'h70, v); chk("R4 count before third tick", v, 998);
      wait_cyc(1);
      bus_read(8'h70, v); chk("R4 count at third tick", v, 997);

      // R6: stop by clearing bit 0
      p0 = pulses;
      bus_write(8'h72, 16'h0084);
      bus_read(8'h70, c0);
      wait_cyc(5 * TICK);
      bus_read(8'h70, v); chk("R6 count frozen", v, c0);
      bus_read(8'h72, v); chk("R6 control after stop", v, 16'h0084);
      bus_write(8'h72, 16'h0085);
      wait_cyc(TICK);
      bus_read(8'h70, v); chk("R6 resumes from frozen value", v, c0 - 1);

      // R5: run out from 3
      bus_write(8'h72, 16'h0084);
      bus_write(8'h70, 16'd3);
      bus_write(8'h72, 16'h0085);
      wait_cyc(3 * TICK - 1);
      bus_read(8'h70, v); chk("R5 count one before expiry", v, 1);
      chk("R5 no early pulse", int'(wdt_expired), 0);
      wait_cyc(1);
      bus_read(8'h70, v); chk("R5 count reached zero", v, 0);
      chk("R5 pulse at zero", int'(wdt_expired), 1);
      wait_cyc(1);
      #1;
      chk("R5 pulse lasts one cycle", int'(wdt_expired), 0);
      wait_cyc(5 * TICK);
      bus_read(8'h70, v); chk("R5 count holds at zero", v, 0);
      chk("R5 exactly one pulse", pulses - p0, 1);

      // R7: keepalive restarts countdown and phase
      p0 = pulses;
      bus_write(8'h70, 16'd5);
      wait_cyc(2 * TICK);
      bus_read(8'h70, v); chk("R7 before keepalive", v, 3);
      bus_write(8'h70, 16'd5);
      wait_cyc(2 * TICK - 1);
      bus_read(8'h70, v); chk("R7 phase restarted", v, 4);
      chk("R7 no pulse during keepalive", pulses - p0, 0);

      // R12: load zero while enabled
      p0 = pulses;
      bus_write(8'h70, 16'd0);
      wait_cyc(3 * TICK);
      bus_read(8'h70, v); chk("R12 zero load count", v, 0);
      chk("R12 zero load no pulse", pulses - p0, 0);

      // R8 and R9: corners of the seconds path, timer stopped
      bus_write(8'h72, 16'h0000);
      sec_req(1);
      chk("R8 one second no reject", int'(sec_rej), 0);
      bus_read(8'h70, v); chk("R8 one second ticks", v, 7);
      sec_req(MAXS);
      bus_read(8'h70, v); chk("R8 max seconds ticks", v, 65531);
      chk("R10 seconds left at max", int'(sec_left), f_left(65531));
      sec_req(0);
      chk("R9 zero rejected", int'(sec_rej), 1);
      bus_read(8'h70, v); chk("R9 zero keeps count", v, 65531);
      sec_req(MAXS + 1);
      chk("R9 above max rejected", int'(sec_rej), 1);
      bus_read(8'h70, v); chk("R9 above max keeps count", v, 65531);
      @(negedge clk); #1;
      chk("R9 reject clears", int'(sec_rej), 0);

      // R8 priority: count write wins over seconds request
      sec_val   = 16'd30;
      sec_load  = 1'b1;
      bus_write(8'h70, 16'd77);
      sec_load  = 1'b0;
      bus_read(8'h70, v); chk("R8 count write has priority", v, 77);

      // R11: unmapped addresses
      bus_write(8'h74, 16'h1234);
      bus_write(8'h71, 16'h00FF);
      bus_read(8'h74, v); chk("R11 unmapped read zero", v, 0);
      bus_read(8'h70, v); chk("R11 count untouched", v, 77);
      bus_read(8'h72, v); chk("R11 control untouched", v, 0);

      // Random mix of seconds requests and count loads, timer stopped
      for (int i = 0; i < 24; i++) begin
         int s;
         int exp_c;
         int d;
         bus_read(8'h70, exp_c);
         s = int'($urandom_range(0, 9000));
         if (i % 4 == 3) s = (i % 8 == 3) ? MAXS : MAXS + 1;
         sec_req(s);
         if (f_ok(s)) exp_c = f_ticks(s);
         chk("R9 random reject flag", int'(sec_rej), f_ok(s) ? 0 : 1);
         bus_read(8'h70, v); chk("R8 random seconds load", v, exp_c);
         chk("R10 random seconds left", int'(sec_left), f_left(exp_c));
         d = int'($urandom_range(0, 65535));
         bus_write(8'h70, 16'(d));
         bus_read(8'h70, v); chk("R2 random count load", v, d);
         chk("R10 random count left", int'(sec_left), f_left(d));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule